// File: doc/BRIEF.md
# Async Receive Error Character Handler

This block sits between an asynchronous character deserializer and the receive byte stream. Each incoming character carries its raw data bits, the received parity bit, a framing-error flag and a break flag. The block masks the data to the configured character length and checks parity in one of three modes. It then decides what to emit from a configurable policy for breaks and a separate one for parity or framing faults. It can forward the character with an exception strobe, substitute a NULL byte, pass the character through, drop it, or expand it into a three-byte escape sequence.

Output bytes travel on a valid/ready stream with a 4-bit status word beside each byte. The deserializer cannot be stalled. A character that arrives while earlier output is still pending is lost, and the next forwarded byte reports that loss.

Top module: `async_rx_err_handler`

## Requirements
- R1: `cfg_len` selects 5, 6, 7 or 8 data bits (codes 0..3). Input bits above the selected length are forced to zero before parity checking and before output.
- R2: `cfg_par_mode` 0 or 3 means no parity. Mode 1 (forced) flags an error when `in_parity` differs from `cfg_odd`. Mode 2 (normal) flags an error unless the data bits plus `in_parity` hold an odd count of ones when `cfg_odd`=1, or an even count when `cfg_odd`=0. When `cfg_no_check`=1, no parity error is ever flagged.
- R3: `out_status` bit 3 is overrun, bit 2 is parity error, bit 1 is framing error and bit 0 is break. A clean character with no pending overrun is forwarded once, with status 0.
- R4: A character with `in_break`=1 is governed only by `cfg_brk_mode`. Code 0 forwards the data with an exception strobe. Code 1 forwards 0x00. Codes 2 and 3 discard the character. Break takes precedence over parity and framing errors.
- R5: A non-break character with a parity or framing error follows `cfg_err_mode`. Code 0 forwards the data with an exception strobe. Code 1 forwards 0x00. Code 3 discards the character. Code 4 emits 0xFF, 0x00 and then the data. Codes 2, 5, 6 and 7 forward the data with its status and no strobe.
- R6: With `cfg_err_mode`=4, a clean character whose output value is 0xFF is emitted as 0xFF followed by 0xFF.
- R7: With `cfg_strip`=1, bit 7 of the forwarded data character is cleared. This is applied before the 0xFF test of R6. Markers and NULL substitutes are not affected.
- R8: `exc_pulse` is high for exactly one cycle, in the first cycle in which the excepted character is presented on the output.
- R9: An accepted character appears on `out_valid` in the next cycle. `out_data` and `out_status` hold while `out_valid`=1 and `out_ready`=0. `in_ready` is high only when no output byte is pending. The bytes of a sequence go out over consecutive handshakes, and all bytes of a sequence carry the same status.
- R10: A character presented while `in_ready`=0 is dropped. The next forwarded character carries status bit 3, and the flag is then cleared. Discarded characters leave the flag pending.
- R11: After reset, `out_valid`=0, `exc_pulse`=0, `in_ready`=1 and no overrun is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_len | input | 2 | Character length code (5 + code bits) |
| cfg_par_mode | input | 2 | Parity mode: 0/3 none, 1 forced, 2 normal |
| cfg_odd | input | 1 | Odd (1) / even (0) select |
| cfg_no_check | input | 1 | Disable parity checking |
| cfg_brk_mode | input | 2 | Break policy |
| cfg_err_mode | input | 3 | Parity/framing error policy |
| cfg_strip | input | 1 | Clear bit 7 of data characters |
| in_valid | input | 1 | Character present from the deserializer |
| in_ready | output | 1 | Block can take a character this cycle |
| in_data | input | 8 | Raw data bits, LSB aligned |
| in_parity | input | 1 | Received parity bit |
| in_frame_err | input | 1 | Framing error indication |
| in_break | input | 1 | Break indication |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Consumer accepts the output byte |
| out_data | output | 8 | Output byte |
| out_status | output | 4 | Status of the character the byte belongs to |
| exc_pulse | output | 1 | One-cycle exception strobe |

## Verification
A wrong disposition decision shows up within one cycle of the character being accepted. The output is then a missing, extra or wrong byte, or a status word with a wrong bit, and the per-clock comparison with the behavioural model catches it at once. Faults in the sequence buffer show up on the second or third handshake of an escape sequence, or as `in_ready` returning too early. A stuck or lost overrun flag surfaces on the next forwarded character after a stall.

// File: rtl/async_rx_err_handler.sv
module async_rx_err_handler (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cfg_len,
  input  logic [1:0] cfg_par_mode,
  input  logic       cfg_odd,
  input  logic       cfg_no_check,
  input  logic [1:0] cfg_brk_mode,
  input  logic [2:0] cfg_err_mode,
  input  logic       cfg_strip,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_parity,
  input  logic       in_frame_err,
  input  logic       in_break,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic [3:0] out_status,
  output logic       exc_pulse
);

  logic [1:0] cnt_q;
  logic [7:0] b0_q, b1_q, b2_q;
  logic [3:0] st_q;
  logic       ovr_q, exc_q;

  logic [7:0] mask, data_m, chr;
  logic       par_exp, par_err, take, pop;
  logic [1:0] n_d;
  logic [7:0] b0_d, b1_d, b2_d;
  logic       exc_d;

  assign mask    = 8'hFF >> (2'd3 - cfg_len);
  assign data_m  = in_data & mask;
  assign par_exp = (cfg_par_mode == 2'd1) ? cfg_odd : (^data_m ^ cfg_odd);
  assign par_err = !cfg_no_check && (cfg_par_mode == 2'd1 || cfg_par_mode == 2'd2)
                   && (in_parity != par_exp);
  assign chr     = cfg_strip ? {1'b0, data_m[6:0]} : data_m;

  assign in_ready   = (cnt_q == 2'd0);
  assign take       = in_valid && in_ready;
  assign out_valid  = (cnt_q != 2'd0);
  assign pop        = out_valid && out_ready;
  assign out_data   = b0_q;
  assign out_status = st_q;
  assign exc_pulse  = exc_q;

  always_comb begin
    n_d   = 2'd1;
    b0_d  = chr;
    b1_d  = 8'h00;
    b2_d  = 8'h00;
    exc_d = 1'b0;
    if (in_break) begin
      case (cfg_brk_mode)
        2'd0:    exc_d = 1'b1;
        2'd1:    b0_d  = 8'h00;
        default: n_d   = 2'd0;
      endcase
    end else if (par_err || in_frame_err) begin
      case (cfg_err_mode)
        3'd0: exc_d = 1'b1;
        3'd1: b0_d  = 8'h00;
        3'd3: n_d   = 2'd0;
        3'd4: begin
          n_d  = 2'd3;
          b0_d = 8'hFF;
          b1_d = 8'h00;
          b2_d = chr;
        end
        default: ;
      endcase
    end else if (cfg_err_mode == 3'd4 && chr == 8'hFF) begin
      n_d  = 2'd2;
      b1_d = 8'hFF;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= 2'd0;
      b0_q  <= 8'h00;
      b1_q  <= 8'h00;
      b2_q  <= 8'h00;
      st_q  <= 4'h0;
      ovr_q <= 1'b0;
      exc_q <= 1'b0;
    end else begin
      exc_q <= 1'b0;
      if (in_valid && !in_ready)
        ovr_q <= 1'b1;
      if (take) begin
        cnt_q <= n_d;
        b0_q  <= b0_d;
        b1_q  <= b1_d;
        b2_q  <= b2_d;
        st_q  <= {ovr_q, par_err, in_frame_err, in_break};
        exc_q <= exc_d && (n_d != 2'd0);
        if (n_d != 2'd0)
          ovr_q <= 1'b0;
      end else if (pop) begin
        cnt_q <= cnt_q - 2'd1;
        b0_q  <= b1_q;
        b1_q  <= b2_q;
      end
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_status)); // R9
  AST_EXC_WITH_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_pulse |-> out_valid && $rose(out_valid)); // R8
  AST_EXC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_pulse |=> !exc_pulse); // R8
  AST_DROP_FLAGS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_ready |=> ovr_q); // R10
  AST_SEQ_STATUS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    pop && cnt_q > 2'd1 |=> out_valid && $stable(out_status)); // R9

endmodule

// File: tb/test_async_rx_err_handler.sv
module test_async_rx_err_handler;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cfg_len = 2'd3, cfg_par_mode = 2'd0, cfg_brk_mode = 2'd0;
  logic       cfg_odd = 1'b0, cfg_no_check = 1'b0, cfg_strip = 1'b0;
  logic [2:0] cfg_err_mode = 3'd0;
  logic       in_valid = 1'b0, in_parity = 1'b0, in_frame_err = 1'b0, in_break = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       out_ready = 1'b0;
  logic       in_ready, out_valid, exc_pulse;
  logic [7:0] out_data;
  logic [3:0] out_status;

  always #4 clk = ~clk;

  async_rx_err_handler i_async_rx_err_handler (
    .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_par_mode(cfg_par_mode),
    .cfg_odd(cfg_odd), .cfg_no_check(cfg_no_check), .cfg_brk_mode(cfg_brk_mode),
    .cfg_err_mode(cfg_err_mode), .cfg_strip(cfg_strip), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_parity(in_parity),
    .in_frame_err(in_frame_err), .in_break(in_break), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_status(out_status),
    .exc_pulse(exc_pulse));

  int checks = 0, fails = 0;
  bit done = 0;
  logic [11:0] q_byte[$];
  string       q_tag[$];
  bit          m_ovr = 0, m_exc = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare();
    chk(out_valid == (q_byte.size() != 0), "R9 out_valid", out_valid, q_byte.size() != 0);
    chk(in_ready == (q_byte.size() == 0), "R9 in_ready", in_ready, q_byte.size() == 0);
    chk(exc_pulse == m_exc, "R8 exc_pulse", exc_pulse, m_exc);
    if (out_valid && q_byte.size() != 0)
      chk({out_status, out_data} == q_byte[0], q_tag[0], {out_status, out_data}, q_byte[0]);
  endtask

  // behavioural reference for one accepted character
  task automatic model_accept(logic [7:0] d, bit p, bit fe, bit brk);
    int bits = 5 + cfg_len;
    int val = d % (1 << bits);
    int ones = 0;
    bit perr = 0;
    int outs[$];
    bit exc = 0;
    string tag = "R1 R2 R3 R7";
    for (int i = 0; i < bits; i++) ones += (val >> i) & 1;
    if (!cfg_no_check) begin
      if (cfg_par_mode == 1) perr = (p != cfg_odd);
      else if (cfg_par_mode == 2) perr = (((ones + p) % 2) != (cfg_odd ? 1 : 0));
    end
    if (cfg_strip) val = val % 128;
    if (brk) begin
      tag = {tag, " R4"};
      if (cfg_brk_mode == 0) begin outs.push_back(val); exc = 1; end
      else if (cfg_brk_mode == 1) outs.push_back(0);
    end else if (perr || fe) begin
      tag = {tag, " R5"};
      case (cfg_err_mode)
        0: begin outs.push_back(val); exc = 1; end
        1: outs.push_back(0);
        3: ;
        4: begin outs.push_back(255); outs.push_back(0); outs.push_back(val); end
        default: outs.push_back(val);
      endcase
    end else begin
      outs.push_back(val);
      if (cfg_err_mode == 4 && val == 255) begin outs.push_back(255); tag = {tag, " R6"}; end
    end
    if (m_ovr) tag = {tag, " R10"};
    foreach (outs[k]) begin
      q_byte.push_back({m_ovr, perr, fe, brk, outs[k][7:0]});
      q_tag.push_back(tag);
    end
    m_exc = exc && outs.size() != 0;
    if (outs.size() != 0) m_ovr = 0;
  endtask

  task automatic step(bit v, logic [7:0] d, bit p, bit fe, bit brk, bit rdy);
    bit empty;
    @(negedge clk);
    compare();
    in_valid = v; in_data = d; in_parity = p; in_frame_err = fe; in_break = brk;
    out_ready = rdy;
    empty = (q_byte.size() == 0);
    m_exc = 0;
    if (!empty && rdy) begin void'(q_byte.pop_front()); void'(q_tag.pop_front()); end
    if (v && !empty) m_ovr = 1;
    if (v && empty) model_accept(d, p, fe, brk);
  endtask

  task automatic drain();
    for (int i = 0; i < 8; i++) step(0, 8'h00, 0, 0, 0, 1);
  endtask

  initial begin
    int n = 0;
    while (!done) begin
      @(posedge clk);
      n++;
      if (n > 150000) begin
        fails++; checks++;
        $display("FAIL watchdog expired R9 actual=%0d expected=%0d", n, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    chk(out_valid == 0 && exc_pulse == 0 && in_ready == 1, "R11 reset outputs",
        {out_valid, exc_pulse, in_ready}, 3'b001);
    // R6 directed: clean 0xFF doubled in marking mode
    cfg_err_mode = 3'd4;
    step(1, 8'hFF, 0, 0, 0, 1);
    drain();
    // R4 precedence: break with framing error, null policy
    cfg_brk_mode = 2'd1; cfg_par_mode = 2'd2;
    step(1, 8'h5A, 1, 1, 1, 1);
    drain();
    // R5 marking sequence with stalls
    step(1, 8'h41, 0, 1, 0, 0);
    step(0, 8'h00, 0, 0, 0, 0);
    step(1, 8'h33, 0, 0, 0, 1);
    drain();
    // R10 overrun carried into next character
    cfg_err_mode = 3'd2;
    step(1, 8'h10, 1, 0, 0, 0);
    step(1, 8'h20, 0, 0, 0, 0);
    step(0, 8'h00, 0, 0, 0, 1);
    step(1, 8'h30, 0, 0, 0, 1);
    drain();
    // randomized sweep over all configurations
    for (int r = 0; r < 6000; r++) begin
      if (r % 40 == 0) begin
        drain();
        cfg_len = 2'($urandom); cfg_par_mode = 2'($urandom);
        cfg_odd = 1'($urandom); cfg_no_check = ($urandom % 5 == 0);
        cfg_brk_mode = 2'($urandom); cfg_err_mode = 3'($urandom);
        cfg_strip = 1'($urandom);
      end
      step($urandom % 3 == 0, ($urandom % 6 == 0) ? 8'hFF : 8'($urandom),
           1'($urandom), $urandom % 6 == 0, $urandom % 9 == 0, $urandom % 4 != 0);
    end
    drain();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule